// File: doc/BRIEF.md
# Coprocessor Bank Window Register

This block lets an 8-bit coprocessor with a 15-bit local address reach any 32 KB window of a 24-bit main address space. The upper nine address bits come from a bank register that the coprocessor loads one bit per write cycle. Each write strobe shifts the register one place toward the low end and inserts the written bit at the top, at address bit 23. The bit that leaves the low end, at address bit 15, is lost. After nine writes the register holds a complete bank number. If fewer writes have happened since the bank was last fully set, some earlier bits are still present in the low positions.

The translated address is the bank register placed in bits 23..15, ORed with the coprocessor's 15-bit window offset in bits 14..0. The offset path has no register, so a new offset appears on the output in the same cycle. A change to the bank appears on the output one clock after the write edge. Reset clears the bank, which places the window at 0x000000–0x007FFF.

Top module: `coproc_bank_window`

## Requirements
- R1: While reset is asserted and after it is released, with no writes, the bank is zero and `phys_addr` equals `{9'b0, win_ofs}`. Reset also overrides a write strobe that is high at the same time.
- R2: `phys_addr[14:0]` always equals `win_ofs` in the same cycle, whatever the bank value.
- R3: On a clock edge with `wr_en` high, the new bank bit 8 (address bit 23) takes the value of `wr_bit`. New bank bits 7..0 (address bits 22..15) take the old bank bits 8..1. The result shows on `phys_addr` from the cycle after that edge.
- R4: The old bank bit 0 (address bit 15) is dropped on a write. Two bank values that differ only in that bit give the same bank after one write.
- R5: On a clock edge with `wr_en` low, the bank does not change, whatever the value of `wr_bit`.
- R6: After nine writes in a row, the bank equals the written bits and depends on nothing written earlier. The first bit written ends up at address bit 15 and the last at address bit 23.
- R7: `phys_addr[23:15]` always equals the bank register, so the window is exactly 32 KB and aligned to 32 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the bank |
| wr_en | input | 1 | Write strobe for one bit into the bank register |
| wr_bit | input | 1 | Data bit 0 of the coprocessor write |
| win_ofs | input | 15 | Coprocessor offset within the window |
| phys_addr | output | 24 | Translated main address |

## Verification
The hardest state to reach is a bank whose low bits are leftovers from an earlier, unrelated sequence of writes. In that state, a partial reload and a full nine-bit reload give visibly different results. The stimulus builds such a history with long random write streams at irregular strobe density. It then issues exactly nine directed writes and checks that none of the history remains. Single writes made after a known all-ones or alternating pattern check that the dropped bit at address 15 really disappears.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

  localparam int unsigned CBW_ADDR_W = 24;
  localparam int unsigned CBW_OFS_W  = 15;

  // One bank update: new bit enters at the top, the lowest bit leaves.
  function automatic logic [CBW_ADDR_W-CBW_OFS_W-1:0] bank_shift_in(
    input logic [CBW_ADDR_W-CBW_OFS_W-1:0] cur,
    input logic                            nbit
  );
    logic [CBW_ADDR_W-CBW_OFS_W-1:0] nxt;
    nxt = cur >> 1;
    nxt[CBW_ADDR_W-CBW_OFS_W-1] = nbit;
    return nxt;
  endfunction

  // Translated address: bank in the upper field, offset in the lower field.
  function automatic logic [CBW_ADDR_W-1:0] addr_join(
    input logic [CBW_ADDR_W-CBW_OFS_W-1:0] bank,
    input logic [CBW_OFS_W-1:0]            ofs
  );
    logic [CBW_ADDR_W-1:0] a;
    a = '0;
    a[CBW_ADDR_W-1:CBW_OFS_W] = bank;
    a[CBW_OFS_W-1:0]          = ofs;
    return a;
  endfunction

endpackage

// File: rtl/cbw_bank_shift.sv
module cbw_bank_shift #(
  parameter int unsigned BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_d;

  // Each stage takes its upper neighbour; the top stage takes the new bit.
  for (genvar g = 0; g < BANK_W; g++) begin : g_stage
    if (g == BANK_W - 1) begin : g_top
      assign bank_d[g] = shift_en ? shift_bit : bank_q[g];
    end else begin : g_low
      assign bank_d[g] = shift_en ? bank_q[g+1] : bank_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

endmodule

// File: rtl/cbw_addr_join.sv
module cbw_addr_join #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 15,
  localparam int unsigned BANK_W = ADDR_W - OFS_W
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    addr = '0;
    addr[ADDR_W-1:OFS_W] = bank;
    addr[OFS_W-1:0]      = ofs;
  end

endmodule

// File: rtl/coproc_bank_window.sv
module coproc_bank_window #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 15,
  localparam int unsigned BANK_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic [OFS_W-1:0]  win_ofs,
  output logic [ADDR_W-1:0] phys_addr
);

  // Named internal events, visible to the bound checker.
  logic              wr_fire;
  logic [BANK_W-1:0] bank_q;

  assign wr_fire = wr_en;

  cbw_bank_shift #(.BANK_W(BANK_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (wr_fire),
    .shift_bit(wr_bit),
    .bank_q   (bank_q)
  );

  cbw_addr_join #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_join (
    .bank(bank_q),
    .ofs (win_ofs),
    .addr(phys_addr)
  );

endmodule

// File: rtl/cbw_checker.sv
module cbw_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 15,
  localparam int unsigned BANK_W = ADDR_W - OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_fire,
  input logic              wr_bit,
  input logic [OFS_W-1:0]  win_ofs,
  input logic [BANK_W-1:0] bank_q,
  input logic [ADDR_W-1:0] phys_addr
);

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bank_q == '0));

  p_ofs_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == win_ofs);

  p_top_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (bank_q[BANK_W-1] == $past(wr_bit)));

  // R3 and R4: lower bits move down one place, and the old bit 0 is gone.
  p_shift_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (bank_q[BANK_W-2:0] == $past(bank_q[BANK_W-1:1])));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(bank_q));

  p_bank_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[ADDR_W-1:OFS_W] == bank_q);

endmodule

bind coproc_bank_window cbw_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_fire  (wr_fire),
  .wr_bit   (wr_bit),
  .win_ofs  (win_ofs),
  .bank_q   (bank_q),
  .phys_addr(phys_addr)
);

// File: tb/tb_coproc_bank_window.sv
module tb_coproc_bank_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_bit = 1'b0;
  logic [14:0] win_ofs = '0;
  logic [23:0] phys_addr;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned model_bank = 0;   // bench's own 9-bit bank value
  bit          done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  coproc_bank_window dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .win_ofs(win_ofs), .phys_addr(phys_addr)
  );

  // Bench restatement: a write halves the bank and adds 256 when the bit is 1.
  function automatic int unsigned next_bank(int unsigned b, bit nb);
    return (b / 2) + (nb ? 256 : 0);
  endfunction

  function automatic int unsigned expect_addr(int unsigned b, int unsigned o);
    return b * 32768 + o;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let the rising edge capture it, and sample at
  // the next falling edge.
  task automatic put_bit(bit b);
    @(negedge clk);
    wr_en  = 1'b1;
    wr_bit = b;
    @(posedge clk);
    model_bank = next_bank(model_bank, b);
    @(negedge clk);
    wr_en  = 1'b0;
    wr_bit = ~b;
  endtask

  task automatic check_addr(string req);
    win_ofs = 15'($urandom);
    #0.5;
    check(req, phys_addr, expect_addr(model_bank, win_ofs));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b1;        // reset must dominate a write strobe
    wr_bit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model_bank = 0;
    check_addr("R1");
    wr_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_addr("R1");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_addr("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_addr("R1");
    win_ofs = 15'h7fff; #0.5; check("R2", phys_addr, 24'h007fff);

    // All ones into the top: R6 full define
    for (int i = 0; i < 9; i++) put_bit(1'b1);
    win_ofs = '0; #0.5; check("R6", phys_addr, 24'hff8000);
    // R4: the old bit 15 is dropped
    put_bit(1'b0);
    win_ofs = '0; #0.5; check("R4", phys_addr, 24'h7f8000);
    // R3: a single 1 after zeros lands at bit 23
    for (int i = 0; i < 9; i++) put_bit(1'b0);
    put_bit(1'b1);
    win_ofs = '0; #0.5; check("R3", phys_addr, 24'h800000);
    // R2 with a nonzero bank
    win_ofs = 15'h1234; #0.5; check("R2", phys_addr, 24'h801234);

    // R5: strobe low, data toggles, bank must hold
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); wr_bit = i[0];
      @(negedge clk); check_addr("R5");
    end

    // R6: random history, then nine known bits, first written at bit 15
    for (int r = 0; r < 20; r++) begin
      int unsigned pat;
      int unsigned nh;
      nh = $urandom_range(1, 12);
      for (int i = 0; i < int'(nh); i++) put_bit(1'($urandom));
      pat = $urandom_range(0, 511);
      for (int i = 0; i < 9; i++) put_bit(pat[i]);
      win_ofs = '0; #0.5;
      check("R6", phys_addr, pat * 32768);
    end

    // Mixed random stream with irregular strobe density: R3 and R7
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) != 0) put_bit(1'($urandom));
      else begin
        @(negedge clk); wr_bit = 1'($urandom);
        @(negedge clk);
      end
      check_addr("R7");
    end

    // Reset in the middle of traffic
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    apply_reset();
    put_bit(1'b1);
    check_addr("R3");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule